// File: doc/BRIEF.md
# Return-Address Stack

This block holds the return addresses of a processor's fetch unit. A push request carries an address, and the block files it one level deeper. A pop request gives back the most recently saved address in the same cycle and then drops one level. The storage has 31 levels. Each level is one address word, 21 bits wide by default. A 5-bit depth pointer selects the current top. Pointer value 0 means the stack is empty, and no storage stands behind it.

Software sees four byte registers through a small select/read/write port. Three of them read and write the entry at the current top. The fourth is a status byte that holds two sticky flags and the pointer.

When the stack fills or is read while empty, the block raises a flag. If the overflow-reset enable is set, it also sends a one-cycle reset request to the chip's reset logic. That reset logic drives a separate device-reset input, which empties the stack but leaves the flags alone. Only the power-on reset clears the flags.

Top module: `ret_stack`

## Requirements
- R1: After power-on reset (`rst_ni` low) the pointer is 0, both flags are 0 and `rst_req_o` is 0. While `dev_rst_i` is high at a clock edge, the pointer goes to 0, `rst_req_o` goes to 0 and the storage is left unchanged.
- R2: A push increments the pointer and then writes `push_addr_i` into the entry the new pointer selects. `pop_addr_o` always shows the entry at the current pointer. A pop at a nonzero pointer decrements the pointer, so the stack returns addresses in last-in, first-out order.
- R3: A push that takes the pointer to 31 stores its address and sets the full flag. If `ovf_rst_en_i` is 1, the same edge also sets the pointer to 0 and raises `rst_req_o` for the following cycle.
- R4: With `ovf_rst_en_i` at 0, a push at pointer 31 sets the full flag, leaves the pointer at 31 and leaves entry 31 unchanged. With the enable at 1, the same push clears the pointer and raises `rst_req_o`.
- R5: A pop at pointer 0 reads zero on `pop_addr_o`, sets the underflow flag and leaves the pointer at 0. It raises `rst_req_o` for one cycle when `ovf_rst_en_i` is 1.
- R6: Reading select 3 returns the status byte. Bit 7 is the full flag, bit 6 is the underflow flag, bit 5 reads 0 and bits 4:0 hold the pointer.
- R7: A write to select 3 loads the pointer from bits 4:0. Writing 0 to bit 7 or to bit 6 clears that flag. Writing 1 leaves the flag unchanged, so software can never set a flag.
- R8: Selects 0, 1 and 2 read the top entry's bits 7:0, 15:8 and 20:16, with bits 7:5 of select 2 reading 0. Writes to these selects change only that byte of the top entry. At pointer 0 they read 0 and a write is ignored.
- R9: A software pop (`sw_pop_i`) only moves the pointer down by one. At pointer 0 it acts as an underflowing pop (R5).
- R10: When several requests are present in one cycle, only the highest one acts. The order, highest first, is: device reset, push, pop, software pop, software write.
- R11: The sticky flags keep their values through a device reset, including the reset the block itself requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| dev_rst_i | input | 1 | Synchronous device reset, clears the pointer only |
| ovf_rst_en_i | input | 1 | Configuration: request a reset on overflow or underflow |
| push_i | input | 1 | Push request |
| push_addr_i | input | 21 | Address to save on push |
| pop_i | input | 1 | Pop request |
| pop_addr_o | output | 21 | Entry at current pointer, zero when empty |
| sw_pop_i | input | 1 | Software pop, pointer decrement only |
| sw_wr_i | input | 1 | Software register write strobe |
| sw_sel_i | input | 2 | Register select: 0/1/2 top-entry bytes, 3 status |
| sw_wdata_i | input | 8 | Software write data |
| sw_rdata_o | output | 8 | Software read data for the selected register |
| ptr_o | output | 5 | Current stack pointer |
| full_o | output | 1 | Sticky full/overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle device reset request |

## Verification
The bench fills the stack to 31 with the enable clear and then pushes again. A design that wraps the pointer or overwrites entry 31 shows a changed pointer or a changed top value. The bench then fills the stack with the enable set and sends a device reset. A design that clears the flags on that reset, or that leaves the pointer at 31, is caught here.

Pops and software pops at pointer 0 show whether underflow is handled: a design that wraps the pointer to 31 or returns stale data fails. Status writes of 1 into the flag bits show whether software can wrongly set a flag. A top-entry write at pointer 0 shows whether a missing entry 0 is wrongly updated. Random requests that arrive together expose any inversion of the priority order.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    SEL_TOS_LO = 2'd0,
    SEL_TOS_HI = 2'd1,
    SEL_TOS_UP = 2'd2,
    SEL_STAT   = 2'd3
  } sw_sel_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_SWPOP = 3'd3,
    OP_SWWR  = 3'd4
  } stk_op_e;
endpackage

// File: rtl/ret_stack_arb.sv
module ret_stack_arb
  import ret_stack_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    sw_pop_i,
  input  logic    sw_wr_i,
  output stk_op_e op_o
);
  // fixed priority: push > pop > sw pop > sw write (device reset handled in ctl)
  always_comb begin
    if (push_i)        op_o = OP_PUSH;
    else if (pop_i)    op_o = OP_POP;
    else if (sw_pop_i) op_o = OP_SWPOP;
    else if (sw_wr_i)  op_o = OP_SWWR;
    else               op_o = OP_NONE;
  end
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5,
  localparam int DEPTH = (1 << PTR_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] ent [0:DEPTH];

  // slot 0 has no storage
  assign ent[0] = '0;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_ent
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && (wr_idx_i == PTR_W'(g)))
        q <= (q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
    assign ent[g] = q;
  end

  assign rd_data_o = ent[rd_idx_i];

  a_r8_no_slot0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wr_idx_i != '0));
endmodule

// File: rtl/ret_stack_swif.sv
module ret_stack_swif
  import ret_stack_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5,
  localparam int LANES = (ADDR_W + 7) / 8,
  localparam int PAD_W = LANES * 8
) (
  input  logic [1:0]        sel_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] tos_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              full_i,
  input  logic              unf_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] tos_wmask_o,
  output logic [ADDR_W-1:0] tos_wdata_o
);
  logic [PAD_W-1:0] tos_pad;
  logic [PAD_W-1:0] mask_pad;
  logic [PAD_W-1:0] data_pad;
  logic [7:0]       status;

  assign tos_pad = PAD_W'(tos_i);
  assign status  = {full_i, unf_i, {(6 - PTR_W){1'b0}}, ptr_i};

  always_comb begin
    mask_pad = '0;
    data_pad = '0;
    rdata_o  = status;
    for (int l = 0; l < LANES; l++) begin
      data_pad[l*8 +: 8] = wdata_i;
      if (sel_i == 2'(l)) begin
        mask_pad[l*8 +: 8] = 8'hff;
        rdata_o            = tos_pad[l*8 +: 8];
      end
    end
    if (sel_i == SEL_STAT) rdata_o = status;
  end

  assign tos_wmask_o = mask_pad[ADDR_W-1:0];
  assign tos_wdata_o = data_pad[ADDR_W-1:0];
endmodule

// File: rtl/ret_stack_ctl.sv
module ret_stack_ctl
  import ret_stack_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5,
  localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic              ovf_rst_en_i,
  input  stk_op_e           op_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [1:0]        sw_sel_i,
  input  logic [7:0]        sw_wdata_i,
  input  logic [ADDR_W-1:0] tos_wmask_i,
  input  logic [ADDR_W-1:0] tos_wdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              full_o,
  output logic              unf_o,
  output logic              rst_req_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  wr_idx_o,
  output logic [ADDR_W-1:0] wr_mask_o,
  output logic [ADDR_W-1:0] wr_data_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic             full_q, full_d, unf_q, unf_d, req_q, req_d, we;

  assign ptr_inc = ptr_q + PTR_W'(1);

  always_comb begin
    ptr_d     = ptr_q;
    full_d    = full_q;
    unf_d     = unf_q;
    req_d     = 1'b0;
    we        = 1'b0;
    wr_idx_o  = ptr_q;
    wr_mask_o = '1;
    wr_data_o = push_addr_i;
    unique case (op_i)
      OP_PUSH: begin
        if (ptr_q == PTR_MAX) begin
          full_d = 1'b1;
          if (ovf_rst_en_i) begin
            req_d = 1'b1;
            ptr_d = '0;
          end
        end else begin
          ptr_d    = ptr_inc;
          we       = 1'b1;
          wr_idx_o = ptr_inc;
          if (ptr_inc == PTR_MAX) begin
            full_d = 1'b1;
            if (ovf_rst_en_i) begin
              req_d = 1'b1;
              ptr_d = '0;
            end
          end
        end
      end
      OP_POP, OP_SWPOP: begin
        if (ptr_q == '0) begin
          unf_d = 1'b1;
          req_d = ovf_rst_en_i;
        end else begin
          ptr_d = ptr_q - PTR_W'(1);
        end
      end
      OP_SWWR: begin
        if (sw_sel_i == SEL_STAT) begin
          ptr_d  = sw_wdata_i[PTR_W-1:0];
          full_d = full_q & sw_wdata_i[7];
          unf_d  = unf_q & sw_wdata_i[6];
        end else if (ptr_q != '0) begin
          we        = 1'b1;
          wr_mask_o = tos_wmask_i;
          wr_data_o = tos_wdata_i;
        end
      end
      default: ;
    endcase
  end

  assign we_o = we & ~dev_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else if (dev_rst_i) begin
      ptr_q <= '0;
      req_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
      unf_q  <= unf_d;
      req_q  <= req_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign full_o    = full_q;
  assign unf_o     = unf_q;
  assign rst_req_o = req_q;

  a_r1_dev_rst_clears_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> (ptr_q == '0) && !req_q);
  a_r11_flags_survive_dev_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> (full_q == $past(full_q)) && (unf_q == $past(unf_q)));
  a_r2_push_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_rst_i && op_i == OP_PUSH && ptr_q < PTR_MAX - PTR_W'(1)) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));
  a_r3_overflow_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_rst_i && op_i == OP_PUSH && ptr_q == PTR_MAX - PTR_W'(1) && ovf_rst_en_i) |=> (ptr_q == '0) && full_q && req_q);
  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_rst_i && op_i == OP_PUSH && ptr_q == PTR_MAX && !ovf_rst_en_i) |=> (ptr_q == PTR_MAX) && full_q);
  a_r5_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_rst_i && (op_i == OP_POP || op_i == OP_SWPOP) && ptr_q == '0) |=> unf_q && (ptr_q == '0));
  a_r7_full_not_set_by_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_q && op_i != OP_PUSH) |=> !full_q);
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic              ovf_rst_en_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  input  logic              sw_pop_i,
  input  logic              sw_wr_i,
  input  logic [1:0]        sw_sel_i,
  input  logic [7:0]        sw_wdata_i,
  output logic [7:0]        sw_rdata_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              full_o,
  output logic              unf_o,
  output logic              rst_req_o
);
  stk_op_e           op;
  logic [PTR_W-1:0]  ptr;
  logic              full, unf, we;
  logic [PTR_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_mask, wr_data, tos, tos_wmask, tos_wdata;

  ret_stack_arb u_arb (
    .push_i   (push_i),
    .pop_i    (pop_i),
    .sw_pop_i (sw_pop_i),
    .sw_wr_i  (sw_wr_i),
    .op_o     (op)
  );

  ret_stack_ctl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dev_rst_i    (dev_rst_i),
    .ovf_rst_en_i (ovf_rst_en_i),
    .op_i         (op),
    .push_addr_i  (push_addr_i),
    .sw_sel_i     (sw_sel_i),
    .sw_wdata_i   (sw_wdata_i),
    .tos_wmask_i  (tos_wmask),
    .tos_wdata_i  (tos_wdata),
    .ptr_o        (ptr),
    .full_o       (full),
    .unf_o        (unf),
    .rst_req_o    (rst_req_o),
    .we_o         (we),
    .wr_idx_o     (wr_idx),
    .wr_mask_o    (wr_mask),
    .wr_data_o    (wr_data)
  );

  ret_stack_mem #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wr_mask_i (wr_mask),
    .wr_data_i (wr_data),
    .rd_idx_i  (ptr),
    .rd_data_o (tos)
  );

  ret_stack_swif #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_swif (
    .sel_i       (sw_sel_i),
    .wdata_i     (sw_wdata_i),
    .tos_i       (tos),
    .ptr_i       (ptr),
    .full_i      (full),
    .unf_i       (unf),
    .rdata_o     (sw_rdata_o),
    .tos_wmask_o (tos_wmask),
    .tos_wdata_o (tos_wdata)
  );

  assign pop_addr_o = tos;
  assign ptr_o      = ptr;
  assign full_o     = full;
  assign unf_o      = unf;
endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dev_rst = 1'b0, en = 1'b0;
  logic          push = 1'b0, pop = 1'b0, sw_pop = 1'b0, sw_wr = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [1:0]    sw_sel = 2'd3;
  logic [7:0]    sw_wdata = '0;
  logic [AW-1:0] pop_addr;
  logic [7:0]    sw_rdata;
  logic [4:0]    ptr;
  logic          full, unf, rst_req;

  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] m_stk [0:31];
  int            m_ptr = 0;
  logic          m_full = 0, m_unf = 0, m_req = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_i(dev_rst), .ovf_rst_en_i(en),
    .push_i(push), .push_addr_i(push_addr), .pop_i(pop), .pop_addr_o(pop_addr),
    .sw_pop_i(sw_pop), .sw_wr_i(sw_wr), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .ptr_o(ptr), .full_o(full), .unf_o(unf), .rst_req_o(rst_req)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_tos();
    return (m_ptr == 0) ? '0 : m_stk[m_ptr];
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] s);
    logic [AW-1:0] t = m_tos();
    case (s)
      2'd0:    return t[7:0];
      2'd1:    return t[15:8];
      2'd2:    return {3'b000, t[20:16]};
      default: return {m_full, m_unf, 1'b0, 5'(m_ptr)};
    endcase
  endfunction

  function automatic void m_step();
    m_req = 1'b0;
    if (dev_rst) begin
      m_ptr = 0;
    end else if (push) begin
      if (m_ptr == 31) begin
        m_full = 1'b1;
        if (en) begin m_req = 1'b1; m_ptr = 0; end
      end else begin
        m_ptr++;
        m_stk[m_ptr] = push_addr;
        if (m_ptr == 31) begin
          m_full = 1'b1;
          if (en) begin m_req = 1'b1; m_ptr = 0; end
        end
      end
    end else if (pop || sw_pop) begin
      if (m_ptr == 0) begin m_unf = 1'b1; m_req = en; end
      else m_ptr--;
    end else if (sw_wr) begin
      if (sw_sel == 2'd3) begin
        m_ptr  = int'(sw_wdata[4:0]);
        m_full = m_full & sw_wdata[7];
        m_unf  = m_unf & sw_wdata[6];
      end else if (m_ptr != 0) begin
        case (sw_sel)
          2'd0:    m_stk[m_ptr][7:0]   = sw_wdata;
          2'd1:    m_stk[m_ptr][15:8]  = sw_wdata;
          default: m_stk[m_ptr][20:16] = sw_wdata[4:0];
        endcase
      end
    end
  endfunction

  // inputs already applied after a negedge
  task automatic cyc(string tag);
    #1;
    check(tag, "pop_addr", int'(pop_addr), int'(m_tos()));
    check(tag, "sw_rdata", int'(sw_rdata), int'(m_read(sw_sel)));
    @(posedge clk);
    m_step();
    @(negedge clk);
    check(tag, "ptr", int'(ptr), m_ptr);
    check(tag, "full", int'(full), int'(m_full));
    check(tag, "unf", int'(unf), int'(m_unf));
    check(tag, "rst_req", int'(rst_req), int'(m_req));
  endtask

  task automatic idle();
    push = 0; pop = 0; sw_pop = 0; sw_wr = 0; dev_rst = 0; sw_sel = 2'd3;
  endtask

  task automatic do_push(logic [AW-1:0] a, string tag);
    idle(); push = 1; push_addr = a; cyc(tag); idle();
  endtask

  task automatic do_pop(string tag);
    idle(); pop = 1; cyc(tag); idle();
  endtask

  task automatic do_wr(logic [1:0] s, logic [7:0] d, string tag);
    idle(); sw_wr = 1; sw_sel = s; sw_wdata = d; cyc(tag); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < 32; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "ptr@por", int'(ptr), 0);
    check("R1", "full@por", int'(full), 0);
    check("R1", "unf@por", int'(unf), 0);
    check("R1", "req@por", int'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: status layout on empty stack
    idle(); sw_sel = 2'd3; cyc("R6");

    // R2/R3/R4: fill with enable clear
    en = 1'b0;
    for (int i = 1; i <= 30; i++) do_push(AW'(32'h1000 * i + i), "R2");
    do_push(21'h1abcde, "R3");
    check("R3", "full@31", int'(full), 1);
    do_push(21'h055555, "R4");
    check("R4", "ptr sat", int'(ptr), 31);
    #1 check("R4", "entry31 kept", int'(pop_addr), 32'h1abcde);
    idle(); sw_sel = 2'd3; cyc("R6");

    // R8: byte writes to top
    do_wr(2'd0, 8'h5a, "R8");
    do_wr(2'd2, 8'hff, "R8");
    idle(); sw_sel = 2'd2; cyc("R8");
    idle(); sw_sel = 2'd0; cyc("R8");

    // R2: LIFO drain
    for (int i = 0; i < 31; i++) do_pop("R2");
    // R5: underflow without reset request
    do_pop("R5");
    #1 check("R5", "pop zero", int'(pop_addr), 0);
    // R8: write to top at pointer 0 ignored
    do_wr(2'd1, 8'hc3, "R8");
    idle(); sw_sel = 2'd1; cyc("R8");

    // R7: writing 1s must not set, 0 clears
    do_wr(2'd3, 8'hc0, "R7");
    do_wr(2'd3, 8'h80, "R7");
    check("R7", "unf cleared", int'(unf), 0);
    do_wr(2'd3, 8'h00, "R7");
    do_wr(2'd3, 8'hc0, "R7");
    check("R7", "no set", int'(full), 0);

    // R9: software pop
    do_wr(2'd3, 8'h03, "R7");
    idle(); sw_pop = 1; cyc("R9"); idle();
    check("R9", "ptr dec", int'(ptr), 2);
    do_wr(2'd3, 8'h00, "R9");
    idle(); sw_pop = 1; en = 1; cyc("R9"); idle();

    // R5 with enable: reset request
    do_pop("R5");
    check("R5", "req", int'(rst_req), 1);

    // R3: fill with enable set, overflow reset
    do_wr(2'd3, 8'h00, "R7");
    for (int i = 1; i <= 31; i++) do_push(AW'(32'h777 + i), "R3");
    check("R3", "ptr zero", int'(ptr), 0);
    check("R3", "req", int'(rst_req), 1);
    // R11: device reset keeps flags
    idle(); dev_rst = 1; cyc("R11"); idle();
    check("R11", "full kept", int'(full), 1);
    // R4 with enable at pointer 31
    do_wr(2'd3, 8'hdf, "R7");
    do_push(21'h1, "R4");
    check("R4", "ptr cleared", int'(ptr), 0);

    // R10: simultaneous requests
    idle(); push = 1; pop = 1; push_addr = 21'h0beef; cyc("R10");
    idle(); pop = 1; sw_wr = 1; sw_sel = 2'd3; sw_wdata = 8'h1f; cyc("R10");
    idle(); dev_rst = 1; push = 1; push_addr = 21'h3; cyc("R10"); idle();
    // R1: device reset
    check("R1", "ptr after dev rst", int'(ptr), 0);

    // random
    for (int i = 0; i < 4000; i++) begin
      string tag;
      idle();
      if ($urandom_range(63) == 0) en = ~en;
      dev_rst   = ($urandom_range(99) == 0);
      push      = ($urandom_range(99) < 45);
      pop       = ($urandom_range(99) < 30);
      sw_pop    = ($urandom_range(99) < 5);
      sw_wr     = ($urandom_range(99) < 12);
      sw_sel    = 2'($urandom_range(3));
      sw_wdata  = 8'($urandom);
      push_addr = AW'($urandom);
      if (sw_wr && sw_sel == 2'd3 && $urandom_range(3) != 0) sw_wdata[7:6] = 2'b11;
      if (dev_rst) tag = "R11";
      else if (push) tag = (m_ptr >= 30) ? "R3" : "R2";
      else if (pop) tag = (m_ptr == 0) ? "R5" : "R2";
      else if (sw_pop) tag = "R9";
      else if (sw_wr) tag = (sw_sel == 2'd3) ? "R7" : "R8";
      else tag = "R6";
      cyc(tag);
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule